// File: doc/BRIEF.md
# Addressed Control Port with Threshold Registers

This block is the control front end of one side of a two-way buffer. A host drives a select line, a three-bit address, a direction line and a transfer enable. Together they pick one of six resources: data access to the queue, data access to the bypass path, and four threshold registers. The four registers hold the almost-empty and almost-full offsets for each direction. The block decodes each access into single-cycle strobes for the neighbouring queue, output register and bypass logic. It also holds the threshold registers and presents their values continuously to the flag logic.

Read data (queue output, bypass output or a threshold value) is captured into an output register. A separate drive-enable output stands in for tri-state control of the data bus. A bypass-mode indication follows the host's address selection. All controls are active low, except the direction line, which is high for a read.

Top module: `porta_ctrl`

## Requirements
- R1: After reset, all four strobes are low, `dataOut` is 0, `bypassOn` is low and all four threshold outputs equal 8.
- R2: An edge on which `csN` is high or `enN` is high produces no strobe in the following cycle and leaves `dataOut` and all threshold outputs unchanged.
- R3: An edge with `csN`=0, `enN`=0, `rdWrN`=0 and address 000 makes `abWrStb` high for the next cycle, with `wrData` equal to the `dataIn` sampled at that edge.
- R4: An edge with `csN`=0, `enN`=0, `rdWrN`=1 and address 000 makes `baRdStb` high for the next cycle and loads `dataOut` with the `fifoRdData` sampled at that edge.
- R5: Address 001 with `csN`=0 and `enN`=0 gives a bypass access. A write makes `bypWrStb` high for the next cycle, with `wrData` equal to the sampled `dataIn`. A read makes `bypRdStb` high for the next cycle and loads `dataOut` with the sampled `bypRdData`.
- R6: A write (`csN`=0, `enN`=0, `rdWrN`=0) to address 100, 101, 110 or 111 loads `dataIn[8:0]` into `ofsAbAe`, `ofsAbAf`, `ofsBaAe` or `ofsBaAf` respectively, visible after that edge. No strobe is raised.
- R7: A read of address 100 to 111 loads `dataOut` with the selected threshold value, zero-extended, and raises no strobe.
- R8: Addresses 010 and 011 have no effect for either direction: no strobe, and `dataOut` and the thresholds are unchanged.
- R9: `bypassOn` goes high after an edge with `csN`=0 and address 001, whatever `enN` is. It goes low after an edge with `csN`=1 or address 000. Otherwise it holds its value.
- R10: `driveEn` is high exactly when `oeN`=0, `csN`=0 and `rdWrN`=1, in the same cycle and without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Select, active low |
| addrIn | input | 3 | Resource address |
| rdWrN | input | 1 | 1 = read, 0 = write |
| enN | input | 1 | Transfer enable, active low |
| oeN | input | 1 | Output enable, active low |
| dataIn | input | 18 | Host write data |
| fifoRdData | input | 18 | Word presented by the return-direction output register |
| bypRdData | input | 18 | Word presented by the return bypass register |
| dataOut | output | 18 | Captured read data |
| driveEn | output | 1 | Host data bus drive enable |
| abWrStb | output | 1 | Write strobe into the outbound queue |
| baRdStb | output | 1 | Read strobe for the return output register |
| bypWrStb | output | 1 | Write strobe into the outbound bypass register |
| bypRdStb | output | 1 | Read strobe for the return bypass register |
| wrData | output | 18 | Write data aligned with the write strobes |
| bypassOn | output | 1 | Bypass mode indication |
| ofsAbAe | output | 9 | Outbound almost-empty offset |
| ofsAbAf | output | 9 | Outbound almost-full offset |
| ofsBaAe | output | 9 | Return almost-empty offset |
| ofsBaAf | output | 9 | Return almost-full offset |

## Verification
The strobes, `wrData`, `dataOut`, `bypassOn` and the thresholds pass through one register each. So the result of the inputs sampled at one rising edge is due in the cycle that follows that edge. The bench drives inputs on the falling edge and compares all of those outputs at the next falling edge. Its model has advanced by exactly one step per edge, so each comparison lines up with that one-cycle delay. `driveEn` is combinational. It is checked one time unit after the inputs change, before any clock edge. The sweep covers every address code and every combination of direction, select, enable and output enable.

// File: rtl/portctl_pkg.sv
package portctl_pkg;

  localparam int NUM_OFS = 4;

  localparam logic [2:0] CODE_QUEUE  = 3'b000;
  localparam logic [2:0] CODE_BYPASS = 3'b001;

  typedef struct packed {
    logic                abWr;
    logic                baRd;
    logic                bypWr;
    logic                bypRd;
    logic [NUM_OFS-1:0]  ofsWr;
    logic [NUM_OFS-1:0]  ofsRd;
  } acc_t;

endpackage

// File: rtl/portctl_decode.sv
module portctl_decode
  import portctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       enN,
  input  logic       rdWrN,
  input  logic [2:0] addrIn,
  output acc_t       accNow,
  output logic       abWrStb,
  output logic       baRdStb,
  output logic       bypWrStb,
  output logic       bypRdStb,
  output logic       bypassOn
);

  logic selected;
  assign selected = !csN && !enN;

  always_comb begin
    accNow = '0;
    if (selected) begin
      if (addrIn == CODE_QUEUE) begin
        accNow.baRd = rdWrN;
        accNow.abWr = !rdWrN;
      end else if (addrIn == CODE_BYPASS) begin
        accNow.bypRd = rdWrN;
        accNow.bypWr = !rdWrN;
      end else if (addrIn[2]) begin
        accNow.ofsRd[addrIn[1:0]] = rdWrN;
        accNow.ofsWr[addrIn[1:0]] = !rdWrN;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abWrStb  <= 1'b0;
      baRdStb  <= 1'b0;
      bypWrStb <= 1'b0;
      bypRdStb <= 1'b0;
    end else begin
      abWrStb  <= accNow.abWr;
      baRdStb  <= accNow.baRd;
      bypWrStb <= accNow.bypWr;
      bypRdStb <= accNow.bypRd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          bypassOn <= 1'b0;
    else if (csN)                       bypassOn <= 1'b0;
    else if (addrIn == CODE_QUEUE)      bypassOn <= 1'b0;
    else if (addrIn == CODE_BYPASS)     bypassOn <= 1'b1;
  end

  assert_idle_no_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (csN || enN) |=> !(abWrStb || baRdStb || bypWrStb || bypRdStb));

  assert_unused_code_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (addrIn == 3'b010 || addrIn == 3'b011) |=> !(abWrStb || baRdStb || bypWrStb || bypRdStb));

  assert_bypass_enter_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && addrIn == CODE_BYPASS) |=> bypassOn);

  assert_bypass_leave_R9: assert property (@(posedge clk) disable iff (!rstN)
    (csN || addrIn == CODE_QUEUE) |=> !bypassOn);

  assert_queue_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !enN && !rdWrN && addrIn == CODE_QUEUE) |=> (abWrStb && !baRdStb));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({abWrStb, baRdStb, bypWrStb, bypRdStb}));

endmodule

// File: rtl/portctl_regs.sv
module portctl_regs
  import portctl_pkg::*;
#(
  parameter int DATA_W   = 18,
  parameter int OFS_W    = 9,
  parameter int OFS_INIT = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  acc_t                            accNow,
  input  logic [DATA_W-1:0]               dataIn,
  input  logic [DATA_W-1:0]               fifoRdData,
  input  logic [DATA_W-1:0]               bypRdData,
  output logic [DATA_W-1:0]               wrData,
  output logic [DATA_W-1:0]               dataOut,
  output logic [NUM_OFS-1:0][OFS_W-1:0]   ofsVal
);

  localparam logic [OFS_W-1:0] OFS_RESET = OFS_W'(OFS_INIT);

  logic               anyRead;
  logic               anyWrite;
  logic [DATA_W-1:0]  readMux;

  assign anyRead  = accNow.baRd || accNow.bypRd || (|accNow.ofsRd);
  assign anyWrite = accNow.abWr || accNow.bypWr;

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                ofsVal[g] <= OFS_RESET;
      else if (accNow.ofsWr[g]) ofsVal[g] <= dataIn[OFS_W-1:0];
    end

    assert_ofs_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      !accNow.ofsWr[g] |=> $stable(ofsVal[g]));
  end

  always_comb begin
    readMux = '0;
    if (accNow.baRd)  readMux = fifoRdData;
    if (accNow.bypRd) readMux = bypRdData;
    for (int i = 0; i < NUM_OFS; i++) begin
      if (accNow.ofsRd[i]) readMux = DATA_W'(ofsVal[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        dataOut <= '0;
    else if (anyRead) dataOut <= readMux;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         wrData <= '0;
    else if (anyWrite) wrData <= dataIn;
  end

  assert_dataout_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !anyRead |=> $stable(dataOut));

  assert_queue_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    accNow.baRd |=> (dataOut == $past(fifoRdData)));

endmodule

// File: rtl/porta_ctrl.sv
module porta_ctrl
  import portctl_pkg::*;
#(
  parameter int DATA_W   = 18,
  parameter int OFS_W    = 9,
  parameter int OFS_INIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic [2:0]        addrIn,
  input  logic              rdWrN,
  input  logic              enN,
  input  logic              oeN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] fifoRdData,
  input  logic [DATA_W-1:0] bypRdData,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn,
  output logic              abWrStb,
  output logic              baRdStb,
  output logic              bypWrStb,
  output logic              bypRdStb,
  output logic [DATA_W-1:0] wrData,
  output logic              bypassOn,
  output logic [OFS_W-1:0]  ofsAbAe,
  output logic [OFS_W-1:0]  ofsAbAf,
  output logic [OFS_W-1:0]  ofsBaAe,
  output logic [OFS_W-1:0]  ofsBaAf
);

  acc_t                          accNow;
  logic [NUM_OFS-1:0][OFS_W-1:0] ofsVal;

  portctl_decode u_decode (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .enN      (enN),
    .rdWrN    (rdWrN),
    .addrIn   (addrIn),
    .accNow   (accNow),
    .abWrStb  (abWrStb),
    .baRdStb  (baRdStb),
    .bypWrStb (bypWrStb),
    .bypRdStb (bypRdStb),
    .bypassOn (bypassOn)
  );

  portctl_regs #(
    .DATA_W   (DATA_W),
    .OFS_W    (OFS_W),
    .OFS_INIT (OFS_INIT)
  ) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .accNow     (accNow),
    .dataIn     (dataIn),
    .fifoRdData (fifoRdData),
    .bypRdData  (bypRdData),
    .wrData     (wrData),
    .dataOut    (dataOut),
    .ofsVal     (ofsVal)
  );

  assign driveEn = !oeN && !csN && rdWrN;

  assign ofsAbAe = ofsVal[0];
  assign ofsAbAf = ofsVal[1];
  assign ofsBaAe = ofsVal[2];
  assign ofsBaAf = ofsVal[3];

  assert_drive_needs_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (csN || !rdWrN) |-> !driveEn);

endmodule

// File: tb/porta_ctrl_bench.sv
module porta_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 18;
  localparam int OW = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csN = 1'b1;
  logic [2:0]    addrIn = '0;
  logic          rdWrN = 1'b1;
  logic          enN = 1'b1;
  logic          oeN = 1'b1;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] fifoRdData = '0;
  logic [DW-1:0] bypRdData = '0;
  logic [DW-1:0] dataOut;
  logic          driveEn;
  logic          abWrStb, baRdStb, bypWrStb, bypRdStb;
  logic [DW-1:0] wrData;
  logic          bypassOn;
  logic [OW-1:0] ofsAbAe, ofsAbAf, ofsBaAe, ofsBaAf;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  porta_ctrl u_porta_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .addrIn(addrIn), .rdWrN(rdWrN),
    .enN(enN), .oeN(oeN), .dataIn(dataIn), .fifoRdData(fifoRdData),
    .bypRdData(bypRdData), .dataOut(dataOut), .driveEn(driveEn),
    .abWrStb(abWrStb), .baRdStb(baRdStb), .bypWrStb(bypWrStb),
    .bypRdStb(bypRdStb), .wrData(wrData), .bypassOn(bypassOn),
    .ofsAbAe(ofsAbAe), .ofsAbAf(ofsAbAf), .ofsBaAe(ofsBaAe), .ofsBaAf(ofsBaAf)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // model state
  logic [OW-1:0] expOfs [4];
  logic [DW-1:0] expOut;
  logic [DW-1:0] expWr;
  logic          expByp;

  task automatic check_all(input string tag, input logic eAbW, input logic eBaR,
                           input logic eBypW, input logic eBypR);
    chk(tag, "abWrStb", abWrStb, eAbW);
    chk(tag, "baRdStb", baRdStb, eBaR);
    chk(tag, "bypWrStb", bypWrStb, eBypW);
    chk(tag, "bypRdStb", bypRdStb, eBypR);
    if (eAbW || eBypW) chk(tag, "wrData", wrData, expWr);
    chk(tag, "dataOut", dataOut, expOut);
    chk(tag, "ofsAbAe", ofsAbAe, expOfs[0]);
    chk(tag, "ofsAbAf", ofsAbAf, expOfs[1]);
    chk(tag, "ofsBaAe", ofsBaAe, expOfs[2]);
    chk(tag, "ofsBaAf", ofsBaAf, expOfs[3]);
    chk("R9", "bypassOn", bypassOn, expByp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    int k = 0;
    for (int i = 0; i < 4; i++) expOfs[i] = 9'd8;
    expOut = '0;
    expWr = '0;
    expByp = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values while still in reset and right after release
    check_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);

    for (int rep = 0; rep < 2; rep++) begin
      for (int code = 0; code < 8; code++) begin
        for (int c = 0; c < 2; c++) begin
          for (int e = 0; e < 2; e++) begin
            for (int rw = 0; rw < 2; rw++) begin
              for (int o = 0; o < 2; o++) begin
                logic sel, eAbW, eBaR, eBypW, eBypR;
                logic [2:0] a;
                string tag;
                k++;
                a = 3'(code);
                csN = c[0];
                enN = e[0];
                rdWrN = rw[0];
                oeN = o[0];
                addrIn = a;
                dataIn = DW'(k * 7919 + 5 + rep * 333);
                fifoRdData = DW'(k * 131 + 'h1111);
                bypRdData = DW'((k * 977) ^ 'h2AAAA);
                #1;
                chk("R10", "driveEn", driveEn, (!o[0] && !c[0] && rw[0]));

                sel = !c[0] && !e[0];
                eAbW = sel && a == 3'd0 && !rw[0];
                eBaR = sel && a == 3'd0 && rw[0];
                eBypW = sel && a == 3'd1 && !rw[0];
                eBypR = sel && a == 3'd1 && rw[0];
                if (eAbW || eBypW) expWr = dataIn;
                if (eBaR) expOut = fifoRdData;
                if (eBypR) expOut = bypRdData;
                if (sel && a[2] && rw[0]) expOut = DW'(expOfs[a[1:0]]);
                if (sel && a[2] && !rw[0]) expOfs[a[1:0]] = dataIn[OW-1:0];
                if (c[0]) expByp = 1'b0;
                else if (a == 3'd0) expByp = 1'b0;
                else if (a == 3'd1) expByp = 1'b1;

                if (!sel) tag = "R2";
                else if (a == 3'd0) tag = rw[0] ? "R4" : "R3";
                else if (a == 3'd1) tag = "R5";
                else if (!a[2]) tag = "R8";
                else tag = rw[0] ? "R7" : "R6";

                @(negedge clk);
                check_all(tag, eAbW, eBaR, eBypW, eBypR);
              end
            end
          end
        end
      end
    end

    done = 1;
    summary();
  end

endmodule